// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This block sits in the decode-to-memory path of a small load-store RISC core. It receives one 32-bit instruction word per cycle, together with the program counter of that instruction and the contents of the register named by the instruction's base field. One clock later it reports four things: whether the word belongs to the load/store family, the kind of memory access to make, the register that is the data destination or source, and the 32-bit address. The register file, the memory and the arithmetic unit lie outside the block.

The block forms addresses in two ways, and the opcode picks between them. The base-relative form adds a signed 17-bit constant to a base register. A base field of zero selects a literal zero as the base, so the same form also serves as an absolute address. A zero constant gives plain register-indirect addressing. The PC-relative form adds a signed 22-bit constant to the address of the following instruction. The load-address variants make no memory access. The address they compute is itself the value that goes into the destination register.

The base register number appears on a combinational output, so the register file can be read in the same cycle the instruction is presented.

Top module: `lsag_top`

## Requirements
- R1: While reset is asserted, and until the first accepted instruction, `res_valid`, `res_hit`, `res_kind`, `res_reg` and `res_addr` are all zero.
- R2: The block registers its result once. If `in_valid` is high before a clock edge, `res_valid` is high after that edge; otherwise it is low. While `res_valid` is low, `res_hit`, `res_kind`, `res_reg` and `res_addr` keep their previous values.
- R3: The instruction fields are: opcode in bits 31:27, data register in bits 26:22, base register in bits 21:17. `rb_sel` always equals bits 21:17 of `instr`, in the same cycle. For a recognised opcode, `res_reg` equals bits 26:22.
- R4: Opcodes 1 (load), 3 (store) and 5 (load address) use base-relative addressing. The address is the sign-extension of bits 16:0 plus `rb_data`.
- R5: In the base-relative form, a base field of 0 makes the base term zero, whatever the value of `rb_data`. The address is then the sign-extended constant alone.
- R6: Opcodes 2 (relative load), 4 (relative store) and 6 (relative load address) use PC-relative addressing. The address is `pc` + 4 + the sign-extension of bits 21:0.
- R7: `res_kind` is 2'b01 (memory read) for opcodes 1 and 2, 2'b10 (memory write) for opcodes 3 and 4, and 2'b00 (no access; the address is the result) for opcodes 5 and 6. It never takes the value 2'b11.
- R8: Any other opcode gives `res_hit` = 0, `res_kind` = 2'b00, `res_reg` = 0 and `res_addr` = 0. Opcodes 1 to 6 give `res_hit` = 1.
- R9: Address arithmetic wraps modulo 2^32. Negative constants in both forms subtract correctly, including when the result crosses zero or the top of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| pc | input | 32 | Address of the presented instruction |
| rb_sel | output | 5 | Base register number for the register-file read port |
| rb_data | input | 32 | Contents of the register named by `rb_sel` |
| res_valid | output | 1 | Result registered from an instruction in the previous cycle |
| res_hit | output | 1 | The instruction belongs to the load/store family |
| res_kind | output | 2 | 00 no access, 01 read, 10 write |
| res_reg | output | 5 | Data destination or source register number |
| res_addr | output | 32 | Effective address, or the load-address result |

## Verification
The hardest case to reach from the ports is the zero base field. A register file that holds zero in its first entry would hide a design that simply passes `rb_data` through. The bench's register model therefore keeps a non-zero pattern in entry 0, so that ignoring the base shows up in the address. Wrap-around also needs deliberate setup. Directed cases place base registers and the PC near both ends of the address space and pair them with negative and large constants. A long run of generated words then mixes all opcodes, including unrecognised ones, with idle gaps that test the hold behaviour.

// File: rtl/lsag_pkg.sv
package lsag_pkg;

    localparam int OPC_W = 5;

    typedef enum logic [OPC_W-1:0] {
        OPC_LD  = 5'd1,
        OPC_LDR = 5'd2,
        OPC_ST  = 5'd3,
        OPC_STR = 5'd4,
        OPC_LA  = 5'd5,
        OPC_LAR = 5'd6
    } ls_opc_e;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10
    } acc_e;

    typedef struct packed {
        logic hit;
        acc_e acc;
        logic use_pc;
    } ctl_t;

endpackage

// File: rtl/lsag_decode.sv
module lsag_decode
    import lsag_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int RAW  = 5,
    parameter int C1_W = 22,
    parameter int C2_W = 17
) (
    input  logic [XLEN-1:0] instr,
    output ctl_t            ctl,
    output logic [RAW-1:0]  ra,
    output logic [RAW-1:0]  rb,
    output logic [XLEN-1:0] c1_ext,
    output logic [XLEN-1:0] c2_ext
);
    localparam int OPC_LSB = XLEN - OPC_W;
    localparam int RA_LSB  = OPC_LSB - RAW;
    localparam int RB_LSB  = RA_LSB - RAW;

    logic [OPC_W-1:0] opc;
    logic [C1_W-1:0]  c1;
    logic [C2_W-1:0]  c2;

    assign opc = instr[XLEN-1:OPC_LSB];
    assign ra  = instr[OPC_LSB-1:RA_LSB];
    assign rb  = instr[RA_LSB-1:RB_LSB];
    assign c1  = instr[C1_W-1:0];
    assign c2  = instr[C2_W-1:0];

    assign c1_ext = {{(XLEN-C1_W){c1[C1_W-1]}}, c1};
    assign c2_ext = {{(XLEN-C2_W){c2[C2_W-1]}}, c2};

    always_comb begin
        ctl = '0;
        case (opc)
            OPC_LD:  ctl = '{hit: 1'b1, acc: ACC_READ,  use_pc: 1'b0};
            OPC_LDR: ctl = '{hit: 1'b1, acc: ACC_READ,  use_pc: 1'b1};
            OPC_ST:  ctl = '{hit: 1'b1, acc: ACC_WRITE, use_pc: 1'b0};
            OPC_STR: ctl = '{hit: 1'b1, acc: ACC_WRITE, use_pc: 1'b1};
            OPC_LA:  ctl = '{hit: 1'b1, acc: ACC_NONE,  use_pc: 1'b0};
            OPC_LAR: ctl = '{hit: 1'b1, acc: ACC_NONE,  use_pc: 1'b1};
            default: ctl = '{hit: 1'b0, acc: ACC_NONE,  use_pc: 1'b0};
        endcase
    end
endmodule

// File: rtl/lsag_agen.sv
module lsag_agen #(
    parameter int XLEN       = 32,
    parameter int RAW        = 5,
    parameter int PC_STEP    = 4,
    parameter bit ZERO_BASE0 = 1'b1
) (
    input  logic            use_pc,
    input  logic [RAW-1:0]  rb,
    input  logic [XLEN-1:0] rb_data,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] c1_ext,
    input  logic [XLEN-1:0] c2_ext,
    output logic [XLEN-1:0] addr
);
    logic [XLEN-1:0] reg_base;
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offs;

    generate
        if (ZERO_BASE0) begin : g_zero_base
            assign reg_base = (rb == '0) ? '0 : rb_data;
        end else begin : g_plain_base
            logic unused_rb;
            assign unused_rb = ^rb;
            assign reg_base  = rb_data;
        end
    endgenerate

    // One adder; the form only steers its operands.
    assign base = use_pc ? (pc + XLEN'(PC_STEP)) : reg_base;
    assign offs = use_pc ? c1_ext : c2_ext;
    assign addr = base + offs;
endmodule

// File: rtl/lsag_top.sv
module lsag_top
    import lsag_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int RAW     = 5,
    parameter int C1_W    = 22,
    parameter int C2_W    = 17,
    parameter int PC_STEP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [XLEN-1:0] instr,
    input  logic [XLEN-1:0] pc,
    output logic [RAW-1:0]  rb_sel,
    input  logic [XLEN-1:0] rb_data,
    output logic            res_valid,
    output logic            res_hit,
    output logic [1:0]      res_kind,
    output logic [RAW-1:0]  res_reg,
    output logic [XLEN-1:0] res_addr
);
    typedef struct packed {
        logic            valid;
        logic            hit;
        acc_e            acc;
        logic [RAW-1:0]  rnum;
        logic [XLEN-1:0] addr;
    } res_t;

    ctl_t            ctl;
    logic [RAW-1:0]  ra;
    logic [RAW-1:0]  rb;
    logic [XLEN-1:0] c1_ext;
    logic [XLEN-1:0] c2_ext;
    logic [XLEN-1:0] agen_addr;
    res_t            res_d;
    res_t            res_q;

    lsag_decode #(
        .XLEN (XLEN),
        .RAW  (RAW),
        .C1_W (C1_W),
        .C2_W (C2_W)
    ) u_decode (
        .instr  (instr),
        .ctl    (ctl),
        .ra     (ra),
        .rb     (rb),
        .c1_ext (c1_ext),
        .c2_ext (c2_ext)
    );

    lsag_agen #(
        .XLEN       (XLEN),
        .RAW        (RAW),
        .PC_STEP    (PC_STEP),
        .ZERO_BASE0 (1'b1)
    ) u_agen (
        .use_pc  (ctl.use_pc),
        .rb      (rb),
        .rb_data (rb_data),
        .pc      (pc),
        .c1_ext  (c1_ext),
        .c2_ext  (c2_ext),
        .addr    (agen_addr)
    );

    assign rb_sel = rb;

    always_comb begin
        res_d       = res_q;
        res_d.valid = in_valid;
        if (in_valid) begin
            if (ctl.hit) begin
                res_d.hit  = 1'b1;
                res_d.acc  = ctl.acc;
                res_d.rnum = ra;
                res_d.addr = agen_addr;
            end else begin
                res_d.hit  = 1'b0;
                res_d.acc  = ACC_NONE;
                res_d.rnum = '0;
                res_d.addr = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid = res_q.valid;
    assign res_hit   = res_q.hit;
    assign res_kind  = res_q.acc;
    assign res_reg   = res_q.rnum;
    assign res_addr  = res_q.addr;

    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!res_valid && $stable(res_addr) && $stable(res_kind)
                       && $stable(res_reg) && $stable(res_hit)));

    // R7
    kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_kind != 2'b11);

    // R8
    miss_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_kind == 2'b00 && res_addr == '0
                                     && res_reg == '0));

    // R5
    zero_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ctl.hit && !ctl.use_pc && rb == '0)
            |=> res_addr == $past(c2_ext));

    // R3
    reg_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ctl.hit) |=> res_reg == $past(instr[XLEN-OPC_W-1:XLEN-OPC_W-RAW]));
endmodule

// File: tb/tb_lsag_top.sv
module tb_lsag_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] instr;
    logic [31:0] pc;
    logic [4:0]  rb_sel;
    logic [31:0] rb_data;
    logic        res_valid;
    logic        res_hit;
    logic [1:0]  res_kind;
    logic [4:0]  res_reg;
    logic [31:0] res_addr;

    int checks = 0;
    int errors = 0;
    logic [31:0] regs [32];
    logic [31:0] seed = 32'h1234_5677;

    logic        m_valid = 1'b0;
    logic        m_hit   = 1'b0;
    logic [1:0]  m_kind  = 2'b00;
    logic [4:0]  m_reg   = 5'd0;
    logic [31:0] m_addr  = 32'd0;
    string       m_tag   = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    lsag_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .instr     (instr),
        .pc        (pc),
        .rb_sel    (rb_sel),
        .rb_data   (rb_data),
        .res_valid (res_valid),
        .res_hit   (res_hit),
        .res_kind  (res_kind),
        .res_reg   (res_reg),
        .res_addr  (res_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x;
        x = s ^ (s << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // Reference: returns {hit, kind, reg, addr} from the requirement text.
    function automatic logic [39:0] ref_out(input logic [31:0] i, input logic [31:0] p,
                                            input logic [31:0] rbd, output string tag);
        int          opc;
        logic [31:0] c1s, c2s, base, offs;
        logic [32:0] sum;
        logic [1:0]  kind;
        opc = int'(i[31:27]);
        c2s = {{15{i[16]}}, i[16:0]};
        c1s = {{10{i[21]}}, i[21:0]};
        tag = "R8";
        if (opc < 1 || opc > 6) return 40'd0;
        if (opc == 2 || opc == 4 || opc == 6) begin
            base = p + 32'd4;
            offs = c1s;
            tag  = "R6";
        end else begin
            base = (i[21:17] == 5'd0) ? 32'd0 : rbd;
            offs = c2s;
            tag  = (i[21:17] == 5'd0) ? "R5" : "R4";
        end
        sum = {1'b0, base} + {1'b0, offs};
        if (sum[32] || offs[31]) tag = {tag, "/R9"};
        kind = (opc <= 2) ? 2'b01 : (opc <= 4) ? 2'b10 : 2'b00;
        return {1'b1, kind, i[26:22], sum[31:0]};
    endfunction

    task automatic compare();
        chk("R2 valid", {31'd0, res_valid}, {31'd0, m_valid});
        chk({m_tag, " hit"}, {31'd0, res_hit}, {31'd0, m_hit});
        chk("R7 kind", {30'd0, res_kind}, {30'd0, m_kind});
        chk("R3 reg", {27'd0, res_reg}, {27'd0, m_reg});
        chk({m_tag, " addr"}, res_addr, m_addr);
    endtask

    task automatic step(input logic v, input logic [31:0] i, input logic [31:0] p);
        logic [39:0] r;
        string       t;
        in_valid = v;
        instr    = i;
        pc       = p;
        rb_data  = regs[i[21:17]];
        #1;
        chk("R3 rb_sel", {27'd0, rb_sel}, {27'd0, i[21:17]});
        m_valid = v;
        if (v) begin
            r = ref_out(i, p, rb_data, t);
            {m_hit, m_kind, m_reg, m_addr} = r;
            m_tag = t;
        end else begin
            m_tag = "R2";
        end
        @(negedge clk);
        compare();
    endtask

    function automatic logic [31:0] enc2(input int op, input int a, input int b, input int c);
        return {op[4:0], a[4:0], b[4:0], c[16:0]};
    endfunction

    function automatic logic [31:0] enc1(input int op, input int a, input int c);
        return {op[4:0], a[4:0], c[21:0]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; instr = 32'd0; pc = 32'd0; rb_data = 32'd0;
        for (int k = 0; k < 32; k++) regs[k] = 32'h0101_0000 * k + 32'h33;
        regs[0] = 32'hDEAD_BEEF;    // must never leak into base-relative addresses
        regs[4] = 32'h0000_0100;
        regs[9] = 32'h0000_2000;
        regs[5] = 32'h0000_0004;
        regs[6] = 32'hFFFF_FFF0;
        repeat (3) @(negedge clk);
        compare();                  // R1 reset state
        in_valid = 1'b1; instr = enc2(1, 3, 4, 8);
        @(negedge clk);
        compare();                  // R1 still zero while held in reset
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        compare();                  // R1 after release, before any instruction

        step(1, enc2(1, 1, 4, 24), 32'h0000_5000);        // R4 load disp
        step(1, enc2(1, 3, 0, 32), 32'h0000_5004);        // R5 direct
        step(1, enc2(3, 4, 9, 0), 32'h0000_5008);         // R4 reg-indirect store
        step(1, enc2(5, 7, 0, 32), 32'h0000_500C);        // R7 load address, no access
        step(0, 32'hFFFF_FFFF, 32'h0);                    // R2 hold
        step(0, enc2(2, 2, 2, 2), 32'h0);                 // R2 hold
        step(1, enc1(2, 12, -48), 32'h0000_1000);         // R6/R9 negative relative
        step(1, enc1(6, 3, 100), 32'h0000_1000);          // R6 relative load address
        step(1, enc1(4, 8, 16), 32'h0000_2000);           // R6 relative store
        step(1, enc2(1, 2, 5, -8), 32'h0);                // R9 crosses zero downward
        step(1, enc2(3, 2, 6, 32), 32'h0);                // R9 wraps past the top
        step(1, enc1(2, 9, 8), 32'hFFFF_FFF8);            // R9 PC wrap
        step(1, enc2(12, 9, 4, 5), 32'h0);                // R8 unknown opcode
        step(1, enc2(0, 31, 31, 77), 32'h0);              // R8 opcode zero
        step(1, enc2(5, 31, 0, -1), 32'h0);               // R5/R9 direct negative

        for (int n = 0; n < 400; n++) begin
            logic [31:0] w, p;
            seed = nxt(seed); w = seed;
            seed = nxt(seed); p = {seed[31:2], 2'b00};
            w[31:27] = {2'b00, w[29:27]} ^ {w[0] & w[1], 4'b0000};
            if (w[3:2] == 2'b00) w[21:17] = 5'd0;
            seed = nxt(seed);
            regs[w[21:17]] = (w[21:17] == 5'd0) ? 32'hDEAD_BEEF : seed;
            step(seed[1:0] != 2'b00, w, p);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule